// File: doc/BRIEF.md
# Voltage Channel Conversion Sequencer

This block drives an external analog-to-digital converter over a request and completion handshake and turns its raw samples into five per-channel voltage results. It raises a one-cycle start request with a channel number, then waits for the converter's completion strobe and sample. In the default configuration it visits the channels in turn and builds sixteen samples into each result by summing them and dividing by sixteen. Runtime configuration can turn averaging off, so that each sample becomes a result directly. It can also lock conversion onto one channel chosen by a three-bit code.

A configuration change never mixes old and new settings inside one result. If the live settings differ from the ones captured when the current sample set began, the next completion discards the set. That channel's result stays as it was, and a fresh set starts with the new settings. The attenuator-bypass request is not used by the sequencer. It is only registered and passed on to the analog front end.

Top module: `vseq_top`

## Requirements
- R1: While reset is high, and on the first clock after it, adc_start is 0, every result is 0 and every valid bit is 0.
- R2: With cfg_single = 0, sample sets visit channel codes 0, 1, 2, 3, 4 and then wrap to 0. Each channel completes its whole set before the next channel gets a request.
- R3: With cfg_avg_off = 0, a set has 16 samples. The stored result is the floor of their sum divided by 16, taken from a 14-bit sum, so sixteen samples of 1023 give 1023.
- R4: With cfg_avg_off = 1, each completed conversion is stored directly as that channel's result.
- R5: With cfg_single = 1, only the channel given by sel_code is requested (000 = 2.5 V, 001 = core supply, 010 = main supply, 011 = 5 V, 100 = 12 V), and codes 101, 110 and 111 select channel 0. adc_chan is always below 5.
- R6: If cfg_avg_off or cfg_single differs at a completion from its value at the start of the set, or sel_code's folded channel differs while single mode is on both at set start and now, the set is dropped. No result changes, and the next set uses the new settings. Changing sel_code in scan mode does not drop a set.
- R7: fe_bypass equals cfg_bypass delayed by one clock, and it does not affect sequencing or results.
- R8: A result is written in a single clock together with its valid bit. A valid bit stays set until reset.
- R9: adc_start is a one-cycle pulse, and no new request is raised until the pending one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_avg_off | input | 1 | 1 = store single conversions, 0 = average 16 |
| cfg_bypass | input | 1 | Attenuator bypass request, forwarded only |
| cfg_single | input | 1 | 1 = convert only the selected channel |
| sel_code | input | 3 | Channel code for single-channel mode |
| adc_data | input | 10 | Converter sample, valid with adc_done |
| adc_done | input | 1 | Converter completion strobe |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 3 | Channel code for the pending request |
| fe_bypass | output | 1 | Registered bypass request to the front end |
| res_flat | output | 50 | Five 10-bit results, channel n at bits [10n+9:10n] |
| res_valid | output | 5 | Per-channel result-written flags |

## Verification
The collision of interest is a configuration change that lands in the same cycle as the sixteenth completion of a set. In that cycle the set could either be written or be dropped, and R6 says it must be dropped. The bench provokes this by toggling the averaging control from inside its converter model, on exactly the strobe that its reference model counts as the last sample of an averaged set. It then checks on the following clocks that the channel's stored result and valid bit are unchanged, and that a new set starts on the same channel. A behavioural reference model is compared against every output on every clock, under randomized converter latency and several data patterns.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic {
    ST_BOUND = 1'b0,
    ST_WAIT  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/vseq_chan_pick.sv
module vseq_chan_pick #(
  parameter int NUM_CH = 5,
  parameter int CH_W   = 3
) (
  input  logic            single,
  input  logic [CH_W-1:0] sel_code,
  input  logic [CH_W-1:0] scan_ptr,
  output logic [CH_W-1:0] folded_sel,
  output logic [CH_W-1:0] next_chan
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  // Codes beyond the last channel fold onto channel 0
  always_comb begin
    if (sel_code > LAST_CH) folded_sel = '0;
    else                    folded_sel = sel_code;
  end

  always_comb begin
    if (single) next_chan = folded_sel;
    else        next_chan = scan_ptr;
  end

endmodule

// File: rtl/vseq_accum.sv
module vseq_accum #(
  parameter int SAMPLE_W = 10,
  parameter int AVG_LOG2 = 4,
  parameter int ACC_W    = SAMPLE_W + AVG_LOG2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                add,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [ACC_W-1:0]    sum_next,
  output logic                last
);

  logic [ACC_W-1:0]    acc_q;
  logic [AVG_LOG2-1:0] cnt_q;

  assign sum_next = acc_q + ACC_W'(sample);
  assign last     = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (add) begin
      acc_q <= sum_next;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a set never advances past its last sample without a clear
  assert_set_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (last && add) |=> (clear || rst || cnt_q == '0));

endmodule

// File: rtl/vseq_result_bank.sv
module vseq_result_bank #(
  parameter int NUM_CH   = 5,
  parameter int SAMPLE_W = 10,
  parameter int CH_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [CH_W-1:0]            wr_idx,
  input  logic [SAMPLE_W-1:0]        wr_data,
  output logic [NUM_CH*SAMPLE_W-1:0] res_flat,
  output logic [NUM_CH-1:0]          res_valid
);

  logic [NUM_CH-1:0] sel_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic [SAMPLE_W-1:0] val_q;
      logic                vld_q;

      assign sel_vec[g] = wr_en && (wr_idx == CH_W'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          val_q <= '0;
          vld_q <= 1'b0;
        end else if (sel_vec[g]) begin
          val_q <= wr_data;
          vld_q <= 1'b1;
        end
      end

      assign res_flat[g*SAMPLE_W +: SAMPLE_W] = val_q;
      assign res_valid[g] = vld_q;
    end
  endgenerate

  // R8: at most one channel is written per clock
  assert_single_write_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));

  // R8: a valid flag is never cleared outside reset
  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((res_valid & $past(res_valid)) == $past(res_valid)));

endmodule

// File: rtl/vseq_top.sv
module vseq_top #(
  parameter int NUM_CH   = 5,
  parameter int SAMPLE_W = 10,
  parameter int AVG_LOG2 = 4,
  parameter int CH_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_avg_off,
  input  logic                       cfg_bypass,
  input  logic                       cfg_single,
  input  logic [CH_W-1:0]            sel_code,
  input  logic [SAMPLE_W-1:0]        adc_data,
  input  logic                       adc_done,
  output logic                       adc_start,
  output logic [CH_W-1:0]            adc_chan,
  output logic                       fe_bypass,
  output logic [NUM_CH*SAMPLE_W-1:0] res_flat,
  output logic [NUM_CH-1:0]          res_valid
);
  import vseq_pkg::*;

  localparam int ACC_W = SAMPLE_W + AVG_LOG2;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_t      state_q;
  logic            start_q, fe_q;
  logic [CH_W-1:0] chan_q, scan_ptr_q, lat_sel_q;
  logic            lat_avg_off_q, lat_single_q;

  logic [CH_W-1:0]     folded_sel, next_chan;
  logic [ACC_W-1:0]    sum_next;
  logic                acc_last;
  logic                take, cfg_moved, finish;
  logic [SAMPLE_W-1:0] wr_data;

  vseq_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .single     (cfg_single),
    .sel_code   (sel_code),
    .scan_ptr   (scan_ptr_q),
    .folded_sel (folded_sel),
    .next_chan  (next_chan)
  );

  assign take      = (state_q == ST_WAIT) && adc_done;
  assign cfg_moved = (cfg_avg_off != lat_avg_off_q) || (cfg_single != lat_single_q) ||
                     (cfg_single && lat_single_q && (folded_sel != lat_sel_q));
  assign finish    = take && !cfg_moved && (lat_avg_off_q || acc_last);
  assign wr_data   = lat_avg_off_q ? adc_data : sum_next[ACC_W-1:AVG_LOG2];

  vseq_accum #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clear    (state_q == ST_BOUND),
    .add      (take && !cfg_moved),
    .sample   (adc_data),
    .sum_next (sum_next),
    .last     (acc_last)
  );

  vseq_result_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (finish),
    .wr_idx    (chan_q),
    .wr_data   (wr_data),
    .res_flat  (res_flat),
    .res_valid (res_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_BOUND;
      start_q       <= 1'b0;
      chan_q        <= '0;
      scan_ptr_q    <= '0;
      lat_sel_q     <= '0;
      lat_avg_off_q <= 1'b0;
      lat_single_q  <= 1'b0;
      fe_q          <= 1'b0;
    end else begin
      fe_q <= cfg_bypass;
      case (state_q)
        ST_BOUND: begin
          lat_avg_off_q <= cfg_avg_off;
          lat_single_q  <= cfg_single;
          lat_sel_q     <= folded_sel;
          chan_q        <= next_chan;
          start_q       <= 1'b1;
          state_q       <= ST_WAIT;
        end
        default: begin
          start_q <= 1'b0;
          if (take) begin
            if (cfg_moved || finish) begin
              state_q <= ST_BOUND;
              if (finish && !lat_single_q)
                scan_ptr_q <= (scan_ptr_q == LAST_CH) ? '0 : scan_ptr_q + 1'b1;
            end else begin
              start_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign adc_start = start_q;
  assign adc_chan  = chan_q;
  assign fe_bypass = fe_q;

  // R9: the request strobe lasts one clock
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  // R9: a request is only issued while waiting on the converter
  assert_start_in_wait_R9: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (state_q == ST_WAIT));

  // R5: channel code stays inside the channel range
  assert_chan_range_R5: assert property (@(posedge clk) disable iff (rst)
    adc_chan <= LAST_CH);

  // R5: in single mode the requested channel is the captured selection
  assert_single_chan_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && lat_single_q) |-> (adc_chan == lat_sel_q));

  // R6: a dropped set leaves every result untouched
  assert_drop_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (take && cfg_moved) |=> $stable(res_flat));

endmodule

// File: tb/sim_vseq_top.sv
module sim_vseq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        avg_req = 1'b0, flip_bit = 1'b0;
  logic        cfg_avg_off, cfg_bypass = 1'b0, cfg_single = 1'b0;
  logic [2:0]  sel_code = 3'd0;
  logic [9:0]  adc_data = '0;
  logic        adc_done = 1'b0;
  logic        adc_start, fe_bypass;
  logic [2:0]  adc_chan;
  logic [49:0] res_flat;
  logic [4:0]  res_valid;

  assign cfg_avg_off = avg_req ^ flip_bit;

  always #2.5 clk = ~clk;

  vseq_top u0 (
    .clk(clk), .rst(rst), .cfg_avg_off(cfg_avg_off), .cfg_bypass(cfg_bypass),
    .cfg_single(cfg_single), .sel_code(sel_code), .adc_data(adc_data),
    .adc_done(adc_done), .adc_start(adc_start), .adc_chan(adc_chan),
    .fe_bypass(fe_bypass), .res_flat(res_flat), .res_valid(res_valid)
  );

  integer n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic integer fold(input integer s);
    return (s > 4) ? 0 : s;
  endfunction

  // Behavioural reference model
  integer m_st, m_ptr, m_chan, m_cnt, m_sum, m_sel;
  bit     m_start, m_fe, m_avgoff, m_single;
  integer m_res [5];
  bit     m_valid [5];

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_start <= 0; m_ptr <= 0; m_chan <= 0; m_cnt <= 0; m_sum <= 0;
      m_sel <= 0; m_avgoff <= 0; m_single <= 0; m_fe <= 0;
      for (int i = 0; i < 5; i++) begin m_res[i] <= 0; m_valid[i] <= 0; end
    end else begin
      m_fe <= cfg_bypass;
      if (m_st == 0) begin
        m_avgoff <= cfg_avg_off;
        m_single <= cfg_single;
        m_sel    <= fold(sel_code);
        m_chan   <= cfg_single ? fold(sel_code) : m_ptr;
        m_start  <= 1; m_cnt <= 0; m_sum <= 0; m_st <= 1;
      end else begin
        m_start <= 0;
        if (adc_done) begin
          if (cfg_avg_off != m_avgoff || cfg_single != m_single ||
              (cfg_single && m_single && fold(sel_code) != m_sel)) begin
            m_st <= 0;
          end else if (m_avgoff || m_cnt == 15) begin
            m_res[m_chan]   <= m_avgoff ? integer'(adc_data) : (m_sum + integer'(adc_data)) / 16;
            m_valid[m_chan] <= 1;
            if (!m_single) m_ptr <= (m_ptr + 1) % 5;
            m_st <= 0;
          end else begin
            m_sum <= m_sum + integer'(adc_data);
            m_cnt <= m_cnt + 1;
            m_start <= 1;
          end
        end
      end
    end
  end

  // Converter model, flip injection and per-clock comparison
  integer pend = 0, nstart = 0, data_mode = 0, seqn = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit     flip_arm = 0, flip_seen = 0;
  integer flip_ch = 0, flip_res = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(adc_start == m_start, "R9 R2 adc_start", adc_start, m_start);
      chk(adc_chan == m_chan[2:0], "R2 R5 adc_chan", adc_chan, m_chan);
      chk(fe_bypass == m_fe, "R7 fe_bypass", fe_bypass, m_fe);
      for (int i = 0; i < 5; i++) begin
        chk(res_flat[i*10 +: 10] == m_res[i][9:0], "R3 R4 R6 result", res_flat[i*10 +: 10], m_res[i]);
        chk(res_valid[i] == m_valid[i], "R8 valid", res_valid[i], m_valid[i]);
      end
    end
    adc_done = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        adc_done = 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        seqn++;
        case (data_mode)
          0: adc_data = lfsr[9:0];
          1: adc_data = 10'd1023;
          default: adc_data = 10'(m_chan * 100 + (seqn % 64));
        endcase
        if (flip_arm && m_st == 1 && m_cnt == 15 && !m_avgoff) begin
          flip_bit  = ~flip_bit;
          flip_arm  = 0;
          flip_seen = 1;
          flip_ch   = m_chan;
          flip_res  = m_res[m_chan];
        end
      end
    end
    if (adc_start) begin
      pend = 1 + (nstart % 3);
      nstart++;
    end
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input integer n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    // R1: reset state
    chk(adc_start == 0, "R1 start in reset", adc_start, 0);
    chk(res_valid == 0, "R1 valid in reset", res_valid, 0);
    chk(res_flat == 0, "R1 results in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 0, "R1 valid after reset", res_valid, 0);

    // R2 R3: averaged scan with random data, then all-max data
    wait_cyc(1500);
    chk(res_valid == 5'h1f, "R2 R8 all channels written", res_valid, 31);
    data_mode = 1;
    wait_cyc(1500);
    for (int i = 0; i < 5; i++)
      chk(res_flat[i*10 +: 10] == 10'd1023, "R3 full-scale average", res_flat[i*10 +: 10], 1023);

    // R6: sel change in scan mode does not drop sets; R7 bypass forwarding
    data_mode = 0;
    sel_code = 3'd2;
    cfg_bypass = 1'b1;
    @(negedge clk);
    chk(fe_bypass == 1'b1, "R7 bypass forwarded", fe_bypass, 1);
    wait_cyc(300);

    // R6: config change on the last sample of an averaged set
    flip_arm = 1;
    wait (flip_seen);
    wait_cyc(3);
    chk(res_flat[flip_ch*10 +: 10] == flip_res[9:0], "R6 dropped set keeps result",
        res_flat[flip_ch*10 +: 10], flip_res);
    chk(adc_chan == flip_ch[2:0], "R6 same channel restarted", adc_chan, flip_ch);

    // R4: averaging off (flip left it on -> set request accordingly)
    avg_req = ~flip_bit;
    data_mode = 2;
    wait_cyc(400);
    cfg_bypass = 1'b0;

    // R5: single-channel mode, code 3 then a folding code
    cfg_single = 1'b1;
    sel_code = 3'd3;
    wait_cyc(60);
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (adc_start) chk(adc_chan == 3'd3, "R5 single channel 3", adc_chan, 3);
    end
    sel_code = 3'd6;
    wait_cyc(60);
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (adc_start) chk(adc_chan == 3'd0, "R5 code 110 folds to 0", adc_chan, 0);
    end
    avg_req = flip_bit;
    wait_cyc(400);
    cfg_single = 1'b0;
    wait_cyc(1500);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule